// File: doc/BRIEF.md
# Sixteen-Pin Configurable I/O Port

This block is one general-purpose I/O port of sixteen pins. Software sets it up through a small synchronous register bus. The bus reaches four control registers: pin direction, output latch, open-drain select and digital-enable. A fifth address returns the sampled pin levels. On the pad side the block drives an output-enable and an output value for each pin, and it samples each pad's input level.

Each pin can drive push-pull or open-drain. In open-drain mode the driver is switched on only to pull the pin low. When the latch holds a one, the pin is released so that an external pull-up can set the level.

After reset every pin is an input, and the digital-enable mask is clear, so every pin counts as analog and reads back as zero. Pad levels pass through a two-flop synchronizer before they reach the read path. A read therefore sees a write or direction change that happened earlier on the same port.

The block holds no state machine. Its only sequential parts are the register file and the synchronizer chain.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register is 0xFFFF (all inputs), and the latch, open-drain and digital-enable registers are 0x0000. Every pad output-enable is low.
- R2: The register select `reg_sel` is decoded as follows: 0 = direction (1 = input), 1 = latch, 2 = pin levels (read only; a write goes to the latch), 3 = open-drain (1 = open-drain), 4 = digital-enable (1 = digital). `rd_data` returns the selected value combinationally.
- R3: Selects 5 to 7 read as zero, and a write to them changes no register.
- R4: A pin whose direction bit is 1 has its output-enable low, whatever its latch and open-drain bits hold.
- R5: A push-pull output pin (direction 0, open-drain 0) has output-enable high, and its output value equals its latch bit.
- R6: An open-drain output pin (direction 0, open-drain 1) has output value 0. Its output-enable is high when the latch bit is 0 and low when the latch bit is 1.
- R7: A read of the pin levels returns 0 for every pin whose digital-enable bit is 0, whatever the pad level.
- R8: A pin set as an output while its digital-enable bit is 0 still drives its latch level on the pad.
- R9: A pad level that is steady before clock edge k appears on the pin-level read after edge k+1, and not after edge k alone.
- R10: A register write takes effect at the clock edge on which `wr_en` is sampled high. The pad outputs reflect it directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| pad_in | input | 16 | Sampled pad levels |
| pad_oe | output | 16 | Per-pin driver enable |
| pad_out | output | 16 | Per-pin driven value |

## Verification
The pad drive is tried with a table of mixed patterns. In these patterns input, push-pull and open-drain pins sit side by side with latch ones and zeros. This separates the three drive modes and catches any swap of the enable and value terms. The same vectors vary the digital-enable mask against the pad levels. A pin that leaks through while analog, or that is masked while digital, shows up in the pin-level read. Directed steps move one pad level and read it after one edge and after two, which pins down the synchronizer depth. Writes to unused selects followed by full readback confirm that they are ignored.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_LAT  = 3'd1,
        SEL_PINS = 3'd2,
        SEL_OD   = 3'd3,
        SEL_DIG  = 3'd4
    } gpio_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [PINS-1:0]  wr_data,
    output logic [PINS-1:0]  dir_q,
    output logic [PINS-1:0]  lat_q,
    output logic [PINS-1:0]  od_q,
    output logic [PINS-1:0]  dig_q
);
    localparam logic [PINS-1:0] ALL_IN = {PINS{1'b1}};

    logic hit_dir, hit_lat, hit_od, hit_dig;

    always_comb begin
        hit_dir = wr_en && (reg_sel == SEL_DIR);
        hit_lat = wr_en && ((reg_sel == SEL_LAT) || (reg_sel == SEL_PINS));
        hit_od  = wr_en && (reg_sel == SEL_OD);
        hit_dig = wr_en && (reg_sel == SEL_DIG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= ALL_IN;
            lat_q <= '0;
            od_q  <= '0;
            dig_q <= '0;
        end else begin
            if (hit_dir) dir_q <= wr_data;
            if (hit_lat) lat_q <= wr_data;
            if (hit_od)  od_q  <= wr_data;
            if (hit_dig) dig_q <= wr_data;
        end
    end

    // R10: a latch write lands at the sampling edge
    a_r10_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_sel == SEL_LAT)) |=> (lat_q == $past(wr_data)));

    // R3: unused selects leave the direction register alone
    a_r3_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_sel > SEL_DIG)) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int PINS = 16
) (
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] lat_q,
    input  logic [PINS-1:0] od_q,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (dir_q[i]) begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
            end else if (od_q[i]) begin
                pad_oe[i]  = ~lat_q[i];
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = lat_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_in,
    input  logic [PINS-1:0] dig_q,
    output logic [PINS-1:0] pin_val
);
    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

    always_comb pin_val = sync_q & dig_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [PINS-1:0]  wr_data,
    output logic [PINS-1:0]  rd_data,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_oe,
    output logic [PINS-1:0]  pad_out
);
    logic [PINS-1:0] dir_q, lat_q, od_q, dig_q, pin_val;

    gpio_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q),
        .dig_q(dig_q)
    );

    gpio_drive #(.PINS(PINS)) u_drive (
        .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    gpio_insync #(.PINS(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dig_q(dig_q),
        .pin_val(pin_val)
    );

    always_comb begin
        unique case (reg_sel)
            SEL_DIR:  rd_data = dir_q;
            SEL_LAT:  rd_data = lat_q;
            SEL_PINS: rd_data = pin_val;
            SEL_OD:   rd_data = od_q;
            SEL_DIG:  rd_data = dig_q;
            default:  rd_data = '0;
        endcase
    end

    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm_q <= '0;
        else if (warm_q != 2) warm_q <= warm_q + 2'd1;
    end

    // R7: analog pins never read high
    a_r7_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_val & ~dig_q) == '0);

    // R4: input pins are never driven
    a_r4_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    // R6: an open-drain pin holding a one is released
    a_r6_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & od_q & lat_q) == '0);

    // R9: pin level read is the pad level two edges back
    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2) |-> (pin_val == ($past(pad_in, 2) & dig_q)));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int PINS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        reg_sel = 3'd0;
    logic [PINS-1:0]   wr_data = '0;
    logic [PINS-1:0]   rd_data, pad_oe, pad_out, pad_in;
    logic [PINS-1:0]   ext = '0;

    int errors = 0;
    int checks = 0;

    always #10ns clk = ~clk;

    for (genvar i = 0; i < PINS; i++) begin : g_loop
        assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext[i];
    end

    gpio_port #(.PINS(PINS)) u_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // stimulus: dir, latch, open-drain, digital-enable, external level
    localparam int NV = 6;
    localparam logic [79:0] VEC [NV] = '{
        {16'h0000, 16'hA5A5, 16'h0000, 16'hFFFF, 16'h0F0F},
        {16'h0000, 16'hF0F0, 16'hFF00, 16'hFFFF, 16'h3C3C},
        {16'hFFFF, 16'h1234, 16'h5555, 16'hFFFF, 16'hC3A5},
        {16'h00FF, 16'h3333, 16'h0F0F, 16'h0FF0, 16'hAAAA},
        {16'hF00F, 16'hFFFF, 16'hFFFF, 16'h00FF, 16'h5A5A},
        {16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [PINS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [PINS-1:0] d);
        reg_sel = sel;
        #1ns;
        d = rd_data;
    endtask

    initial begin
        #(20ns * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [PINS-1:0] v, e_oe, e_out, e_pin;
        logic [PINS-1:0] dir, lat, od, dig, x;

        repeat (3) @(negedge clk);
        // R1 reset values
        rd(3'd0, v); check("R1", "dir reset", v, 16'hFFFF);
        rd(3'd1, v); check("R1", "latch reset", v, 16'h0000);
        rd(3'd3, v); check("R1", "od reset", v, 16'h0000);
        rd(3'd4, v); check("R1", "dig reset", v, 16'h0000);
        check("R1", "oe reset", pad_oe, 16'h0000);
        rst_n = 1'b1;

        // table walk: R2 R4 R5 R6 R7 R8
        for (int n = 0; n < NV; n++) begin
            {dir, lat, od, dig, x} = VEC[n];
            ext = x;
            wr(3'd0, dir); wr(3'd1, lat); wr(3'd3, od); wr(3'd4, dig);
            repeat (3) @(negedge clk);
            e_oe  = ~dir & (~od | ~lat);
            e_out = lat & ~od & ~dir;
            e_pin = ((e_oe & e_out) | (~e_oe & x)) & dig;
            check("R4/R5/R6", "pad_oe", pad_oe, e_oe);
            check("R5/R6/R8", "pad_out", pad_out, e_out);
            rd(3'd2, v); check("R7", "pin read", v, e_pin);
            rd(3'd0, v); check("R2", "dir readback", v, dir);
            rd(3'd1, v); check("R2", "latch readback", v, lat);
        end

        // R2: write through the pin-level address lands in the latch
        wr(3'd2, 16'h6C6C);
        rd(3'd1, v); check("R2", "latch via pin addr", v, 16'h6C6C);

        // R3: unused selects ignored and read zero
        wr(3'd5, 16'h1111); wr(3'd6, 16'h2222); wr(3'd7, 16'h3333);
        rd(3'd7, v); check("R3", "unused reads zero", v, 16'h0000);
        rd(3'd0, v); check("R3", "dir kept", v, 16'h0000);
        rd(3'd1, v); check("R3", "latch kept", v, 16'h6C6C);
        rd(3'd3, v); check("R3", "od kept", v, 16'h0000);
        rd(3'd4, v); check("R3", "dig kept", v, 16'h0000);

        // R8: analog output pin still drives latch level
        check("R8", "analog pin drives", pad_out, 16'h6C6C);

        // R10: outputs change right after the write edge
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 3'd1; wr_data = 16'h0001;
        #1ns; check("R10", "before edge", pad_out, 16'h6C6C);
        @(negedge clk);
        wr_en = 1'b0;
        check("R10", "after edge", pad_out, 16'h0001);

        // R9: synchronizer depth on a digital input pin
        wr(3'd0, 16'hFFFF); wr(3'd4, 16'hFFFF);
        ext = 16'h0000;
        repeat (3) @(negedge clk);
        ext = 16'h8001;
        @(negedge clk);
        rd(3'd2, v); check("R9", "one edge old", v, 16'h0000);
        @(negedge clk);
        rd(3'd2, v); check("R9", "two edges new", v, 16'h8001);

        // R7: clearing digital-enable masks immediately
        wr(3'd4, 16'h0001);
        rd(3'd2, v); check("R7", "mask applied", v, 16'h0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule